// File: doc/BRIEF.md
# Oversampled serial receiver with sleep and wakeup

This block recovers characters from an asynchronous serial line that is sampled at sixteen times the bit rate. A one-cycle enable, `tick16`, paces all sampling, so the baud-rate divider is outside the block. Each character has one start bit, eight data bits, an optional ninth data bit and one stop bit, sent least significant bit first. The receiver checks the start bit, takes a majority vote on each data bit and the stop bit, and presents the word together with its parity and framing status.

An idle-line detector raises a flag after one full character time of ones. The count of ones can begin right after the start bit, or only once the stop bit has been sampled. A sleep request mutes the receiver until a wake condition occurs. The wake condition is either an idle line or a character whose final data bit is 1. The serial input comes from the receive pin, from an internal transmit stream looped back, or from the shared transmit pin when that pin is used as a single wire.

Top module: `uart_wake_rx`

## Requirements
- R1: With `nineBit`=0 a character has eight data bits, LSB first, and `rxBit9` reads 0. With `nineBit`=1 a ninth data bit follows bit 7 and appears on `rxBit9`.
- R2: A low level seen on a tick starts a character only if the line is still low on the 8th tick of that bit (tick index 7, where the first low tick is index 0). Otherwise the character is dropped and no `rxValid` occurs.
- R3: Each data bit and the stop bit take the majority of tick indices 6, 7 and 8 of the bit, so an inverted sample on any one of those ticks does not change the result.
- R4: With `parityEn`=1 the last data bit (bit 7, or the ninth bit in 9-bit mode) is the parity bit. `parityErr` is 1 when the XOR of all received data bits differs from `parityOdd` (0 even, 1 odd). With `parityEn`=0, `parityErr` is 0.
- R5: A stop bit that votes 0 sets `frameErr` with that character, and the data is still delivered.
- R6: With `idleLong`=0, ones are counted from the first data-bit tick onward. `idleFlag` rises once 160 consecutive one-ticks have been counted in 8-bit mode (176 in 9-bit mode).
- R7: With `idleLong`=1, ones are counted only after the stop-bit sample. The same tick totals apply.
- R8: `idleFlag` stays high until the next start bit is detected, and then clears.
- R9: A `sleepReq` pulse sets `asleep`. While asleep, `rxValid` and `idleFlag` are suppressed, except for the waking character of R11.
- R10: With `wakeAddr`=0, an idle line that is newly reached while asleep clears `asleep`, and no idle flag is raised for it.
- R11: With `wakeAddr`=1, a character whose final data bit is 1 clears `asleep` and is itself delivered with `rxValid`. Characters whose final bit is 0 stay suppressed.
- R12: With `loopEn`=0 the receiver reads `rxPin`. With `loopEn`=1 and `singleWire`=0 it reads `loopTx`. With `loopEn`=1 and `singleWire`=1 it reads `txPinIn`. The unselected inputs have no effect.
- R13: `rxValid` is a one-cycle pulse on the tick that samples the middle of the stop bit. The data and flag outputs hold until the next delivered character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversample enable, 16 per bit |
| rxPin | input | 1 | External receive pin |
| loopTx | input | 1 | Internal transmit stream |
| txPinIn | input | 1 | Level read back from the transmit pin |
| loopEn | input | 1 | Take the input from the transmit side |
| singleWire | input | 1 | With loopEn, read the transmit pin |
| nineBit | input | 1 | Nine data bits per character |
| parityEn | input | 1 | Last data bit is parity |
| parityOdd | input | 1 | Odd parity when 1, even when 0 |
| idleLong | input | 1 | Count idle ones only after the stop bit |
| wakeAddr | input | 1 | Wake on final-bit mark rather than idle |
| sleepReq | input | 1 | Pulse to enter sleep |
| rxData | output | 8 | Received data bits 0..7 |
| rxBit9 | output | 1 | Ninth data bit |
| rxValid | output | 1 | Character delivered strobe |
| parityErr | output | 1 | Parity mismatch for this character |
| frameErr | output | 1 | Stop bit read as 0 |
| idleFlag | output | 1 | Idle line detected |
| asleep | output | 1 | Receiver is muted |

## Verification
`rxValid` and the character outputs change at the clock edge that consumes tick index 8 of the stop bit. The driver tasks hold each bit for sixteen ticks, and the scoreboard monitor reads outputs on the falling edge, so it compares whatever was registered at that edge without needing a cycle count. `asleep` changes one edge after a `sleepReq` pulse and is read on the next falling edge. The idle flag and idle wakeup are due after 160 counted one-ticks, so the bench samples several ticks before and several ticks after that point, which keeps the short and long counting modes clearly apart.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;

  localparam int BIT_IDX_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_e;

  // strobes from the sequencer to the datapath, already qualified by the tick
  typedef struct packed {
    logic                 startFound;
    logic                 bitTake;
    logic                 stopTake;
    logic                 idleCountEn;
    logic [BIT_IDX_W-1:0] bitIdx;
  } rxStrobe_t;

endpackage

// File: rtl/uart_wake_rx_ctrl.sv
module uart_wake_rx_ctrl
  import uart_wake_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      rxLine,
  input  logic      nineBit,
  input  logic      idleLong,
  output rxStrobe_t strb
);

  localparam int OS_W      = $clog2(OVERSAMPLE);
  localparam int START_CHK = OVERSAMPLE / 2 - 1;
  localparam int MID_TICK  = OVERSAMPLE / 2;

  rxState_e             state;
  logic [OS_W-1:0]      tickCnt;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [BIT_IDX_W-1:0] lastIdx;
  logic                 bitEnd;

  assign lastIdx = nineBit ? BIT_IDX_W'(DATA_W) : BIT_IDX_W'(DATA_W - 1);
  assign bitEnd  = (tickCnt == OS_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (tick16) begin
      unique case (state)
        ST_IDLE: begin
          if (!rxLine) begin
            state   <= ST_START;
            tickCnt <= OS_W'(1);
          end
        end
        ST_START: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == OS_W'(START_CHK) && rxLine) begin
            state <= ST_IDLE;
          end else if (bitEnd) begin
            state  <= ST_DATA;
            bitIdx <= '0;
          end
        end
        ST_DATA: begin
          tickCnt <= tickCnt + 1'b1;
          if (bitEnd) begin
            if (bitIdx == lastIdx) state <= ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_STOP: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == OS_W'(MID_TICK)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.startFound  = tick16 && (state == ST_IDLE) && !rxLine;
    strb.bitTake     = tick16 && (state == ST_DATA) && (tickCnt == OS_W'(MID_TICK));
    strb.stopTake    = tick16 && (state == ST_STOP) && (tickCnt == OS_W'(MID_TICK));
    strb.idleCountEn = idleLong ? (state == ST_IDLE) : (state != ST_START);
    strb.bitIdx      = bitIdx;
  end

endmodule

// File: rtl/uart_wake_rx_dp.sv
module uart_wake_rx_dp
  import uart_wake_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxLine,
  input  rxStrobe_t         strb,
  input  logic              nineBit,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              wakeAddr,
  input  logic              sleepReq,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxValid,
  output logic              parityErr,
  output logic              frameErr,
  output logic              idleFlag,
  output logic              asleep
);

  localparam int IDLE_W = $clog2((DATA_W + 3) * OVERSAMPLE + 1);

  logic [1:0]        vote;
  logic              bitNow;
  logic [DATA_W:0]   frameBits;
  logic              lastBit;
  logic              deliver;
  logic [IDLE_W-1:0] idleCnt;
  logic [IDLE_W-1:0] idleTh;
  logic              idleHit;
  logic              wakeNow;

  // two earlier samples plus the live one form the vote
  assign bitNow  = (vote[1] & vote[0]) | (vote[1] & rxLine) | (vote[0] & rxLine);
  assign lastBit = nineBit ? frameBits[DATA_W] : frameBits[DATA_W-1];
  assign deliver = strb.stopTake && (!asleep || (wakeAddr && lastBit));
  assign idleTh  = nineBit ? IDLE_W'((DATA_W + 3) * OVERSAMPLE)
                           : IDLE_W'((DATA_W + 2) * OVERSAMPLE);
  assign idleHit = tick16 && strb.idleCountEn && rxLine && (idleCnt == idleTh - 1'b1);
  assign wakeNow = (idleHit && !wakeAddr) || (strb.stopTake && wakeAddr && lastBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vote      <= 2'b11;
      frameBits <= '0;
      idleCnt   <= '0;
    end else begin
      if (tick16) begin
        vote <= {vote[0], rxLine};
        if (!strb.idleCountEn || !rxLine) idleCnt <= '0;
        else if (idleCnt < idleTh)        idleCnt <= idleCnt + 1'b1;
      end
      if (strb.startFound) begin
        frameBits <= '0;
      end else if (strb.bitTake) begin
        for (int i = 0; i <= DATA_W; i++) begin
          if (strb.bitIdx == BIT_IDX_W'(i)) frameBits[i] <= bitNow;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxBit9    <= 1'b0;
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      idleFlag  <= 1'b0;
      asleep    <= 1'b0;
    end else begin
      rxValid <= deliver;
      if (deliver) begin
        rxData    <= frameBits[DATA_W-1:0];
        rxBit9    <= nineBit & frameBits[DATA_W];
        parityErr <= parityEn & ((^frameBits) != parityOdd);
        frameErr  <= !bitNow;
      end
      if (strb.startFound)         idleFlag <= 1'b0;
      else if (idleHit && !asleep) idleFlag <= 1'b1;
      if (sleepReq)     asleep <= 1'b1;
      else if (wakeNow) asleep <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxPin,
  input  logic              loopTx,
  input  logic              txPinIn,
  input  logic              loopEn,
  input  logic              singleWire,
  input  logic              nineBit,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              idleLong,
  input  logic              wakeAddr,
  input  logic              sleepReq,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxValid,
  output logic              parityErr,
  output logic              frameErr,
  output logic              idleFlag,
  output logic              asleep
);

  logic      rxLine;
  rxStrobe_t strb;

  assign rxLine = !loopEn ? rxPin : (singleWire ? txPinIn : loopTx);

  uart_wake_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .nineBit(nineBit), .idleLong(idleLong), .strb(strb)
  );

  uart_wake_rx_dp #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine), .strb(strb),
    .nineBit(nineBit), .parityEn(parityEn), .parityOdd(parityOdd),
    .wakeAddr(wakeAddr), .sleepReq(sleepReq),
    .rxData(rxData), .rxBit9(rxBit9), .rxValid(rxValid),
    .parityErr(parityErr), .frameErr(frameErr),
    .idleFlag(idleFlag), .asleep(asleep)
  );

endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk (
  input logic clk,
  input logic rstN,
  input logic rxLine,
  input logic nineBit,
  input logic parityEn,
  input logic wakeAddr,
  input logic sleepReq,
  input logic rxBit9,
  input logic rxValid,
  input logic parityErr,
  input logic idleFlag,
  input logic asleep
);

  AST_BIT9_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !nineBit) |-> !rxBit9); // R1

  AST_PARITY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parityEn) |-> !parityErr); // R4

  AST_IDLE_CLEAR_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idleFlag) |-> $past(!rxLine)); // R8

  AST_NO_IDLE_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleFlag) |-> !$past(asleep)); // R9

  AST_NO_VALID_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !wakeAddr) |-> !$past(asleep)); // R9

  AST_MARK_WAKE_DELIVERS: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(asleep) && wakeAddr && !$past(sleepReq)) |-> rxValid); // R11

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R13

endmodule

bind uart_wake_rx uart_wake_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .rxLine(rxLine), .nineBit(nineBit),
  .parityEn(parityEn), .wakeAddr(wakeAddr), .sleepReq(sleepReq),
  .rxBit9(rxBit9), .rxValid(rxValid), .parityErr(parityErr),
  .idleFlag(idleFlag), .asleep(asleep)
);

// File: tb/uart_wake_rx_bench.sv
module uart_wake_rx_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic rxPin = 1'b1, loopTx = 1'b1, txPinIn = 1'b1;
  logic loopEn = 1'b0, singleWire = 1'b0, nineBit = 1'b0;
  logic parityEn = 1'b0, parityOdd = 1'b0, idleLong = 1'b0;
  logic wakeAddr = 1'b0, sleepReq = 1'b0;
  logic [7:0] rxData;
  logic rxBit9, rxValid, parityErr, frameErr, idleFlag, asleep;

  int checks = 0;
  int errors = 0;
  int drvSel = 0;
  bit prevValid = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] d;
    logic       b9;
    logic       pe;
    logic       fe;
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) tick16 <= ~tick16;

  uart_wake_rx u_uart_wake_rx (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxPin(rxPin), .loopTx(loopTx),
    .txPinIn(txPinIn), .loopEn(loopEn), .singleWire(singleWire),
    .nineBit(nineBit), .parityEn(parityEn), .parityOdd(parityOdd),
    .idleLong(idleLong), .wakeAddr(wakeAddr), .sleepReq(sleepReq),
    .rxData(rxData), .rxBit9(rxBit9), .rxValid(rxValid),
    .parityErr(parityErr), .frameErr(frameErr), .idleFlag(idleFlag),
    .asleep(asleep)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setLine(input logic v);
    case (drvSel)
      1:       loopTx  = v;
      2:       txPinIn = v;
      default: rxPin   = v;
    endcase
  endtask

  task automatic tickOnce();
    @(negedge clk);
    while (!tick16) @(negedge clk);
  endtask

  task automatic waitTicks(input int n);
    repeat (n) tickOnce();
  endtask

  task automatic sendBit(input logic v, input int glitch);
    for (int i = 0; i < 16; i++) begin
      tickOnce();
      setLine((i == glitch) ? ~v : v);
    end
  endtask

  task automatic sendFrame(input logic [8:0] d, input logic stopV, input int glitch);
    sendBit(1'b0, -1);
    for (int i = 0; i < (nineBit ? 9 : 8); i++) sendBit(d[i], glitch);
    sendBit(stopV, -1);
    if (!stopV) sendBit(1'b1, -1);
  endtask

  task automatic expectFrame(input logic [8:0] d, input logic fe, input string req);
    expItem_t it;
    logic [8:0] bits;
    bits   = nineBit ? d : {1'b0, d[7:0]};
    it.d   = d[7:0];
    it.b9  = bits[8];
    it.pe  = parityEn && ((^bits) != parityOdd);
    it.fe  = fe;
    it.req = req;
    expQ.push_back(it);
  endtask

  task automatic pulseSleep();
    @(negedge clk) sleepReq = 1'b1;
    @(negedge clk) sleepReq = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        check(!prevValid, "R13", "rxValid wider than one cycle", 32'(rxValid), 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R9", "unexpected rxValid", 32'(rxData), 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(rxData == it.d, it.req, "rxData", 32'(rxData), 32'(it.d));
          check(rxBit9 == it.b9, it.req, "rxBit9", 32'(rxBit9), 32'(it.b9));
          check(parityErr == it.pe, it.req, "parityErr", 32'(parityErr), 32'(it.pe));
          check(frameErr == it.fe, it.req, "frameErr", 32'(frameErr), 32'(it.fe));
        end
      end
      prevValid = rxValid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "R13", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(rxValid == 0 && idleFlag == 0 && asleep == 0 && rxData == 0,
          "R13", "reset state", 32'({rxValid, idleFlag, asleep, rxData}), 0);
    rstN = 1'b1;
    waitTicks(20);

    // R1: both character formats
    expectFrame(9'h0A5, 1'b0, "R1"); sendFrame(9'h0A5, 1'b1, -1);
    nineBit = 1'b1;
    expectFrame(9'h13C, 1'b0, "R1"); sendFrame(9'h13C, 1'b1, -1);
    expectFrame(9'h0C3, 1'b0, "R1"); sendFrame(9'h0C3, 1'b1, -1);
    nineBit = 1'b0;

    // R4: parity even / odd, 8 and 9 bits
    parityEn = 1'b1;
    expectFrame(9'h003, 1'b0, "R4"); sendFrame(9'h003, 1'b1, -1);
    expectFrame(9'h007, 1'b0, "R4"); sendFrame(9'h007, 1'b1, -1);
    parityOdd = 1'b1;
    expectFrame(9'h007, 1'b0, "R4"); sendFrame(9'h007, 1'b1, -1);
    nineBit = 1'b1; parityOdd = 1'b0;
    expectFrame(9'h10F, 1'b0, "R4"); sendFrame(9'h10F, 1'b1, -1);
    nineBit = 1'b0; parityEn = 1'b0;

    // R5: stop bit low
    expectFrame(9'h05A, 1'b1, "R5"); sendFrame(9'h05A, 1'b0, -1);

    // R3: single inverted sample inside the vote window
    expectFrame(9'h055, 1'b0, "R3"); sendFrame(9'h055, 1'b1, 6);
    expectFrame(9'h0AA, 1'b0, "R3"); sendFrame(9'h0AA, 1'b1, 7);
    expectFrame(9'h0C6, 1'b0, "R3"); sendFrame(9'h0C6, 1'b1, 8);

    // R2: short low pulse is not a start bit
    for (int i = 0; i < 4; i++) begin tickOnce(); setLine(1'b0); end
    tickOnce(); setLine(1'b1);
    waitTicks(40);
    check(expQ.size() == 0, "R2", "glitch produced no character", 32'(expQ.size()), 0);
    expectFrame(9'h081, 1'b0, "R2"); sendFrame(9'h081, 1'b1, -1);

    // R6: short idle counting
    idleLong = 1'b0;
    expectFrame(9'h0FF, 1'b0, "R6"); sendFrame(9'h0FF, 1'b1, -1);
    waitTicks(12);
    check(idleFlag == 0, "R6", "idle too early", 32'(idleFlag), 0);
    waitTicks(10);
    check(idleFlag == 1, "R6", "idle after char time", 32'(idleFlag), 1);

    // R8: next start clears the flag
    expectFrame(9'h000, 1'b0, "R8"); sendFrame(9'h000, 1'b1, -1);
    check(idleFlag == 0, "R8", "idle cleared by start", 32'(idleFlag), 0);

    // R7: long idle counting
    idleLong = 1'b1;
    expectFrame(9'h0FF, 1'b0, "R7"); sendFrame(9'h0FF, 1'b1, -1);
    waitTicks(12);
    check(idleFlag == 0, "R7", "no idle from data ones", 32'(idleFlag), 0);
    waitTicks(128);
    check(idleFlag == 0, "R7", "idle before char time", 32'(idleFlag), 0);
    waitTicks(30);
    check(idleFlag == 1, "R7", "idle after stop plus char time", 32'(idleFlag), 1);
    idleLong = 1'b0;

    // R9 / R10: sleep, wake on idle
    wakeAddr = 1'b0;
    pulseSleep();
    check(asleep == 1, "R9", "asleep after request", 32'(asleep), 1);
    sendFrame(9'h012, 1'b1, -1);
    waitTicks(12);
    check(asleep == 1, "R9", "still asleep after character", 32'(asleep), 1);
    waitTicks(170);
    check(asleep == 0, "R10", "woken by idle line", 32'(asleep), 0);
    check(idleFlag == 0, "R9", "idle flag muted for wake", 32'(idleFlag), 0);
    expectFrame(9'h034, 1'b0, "R10"); sendFrame(9'h034, 1'b1, -1);

    // R11: sleep, wake on final-bit mark
    wakeAddr = 1'b1;
    waitTicks(170);
    pulseSleep();
    sendFrame(9'h011, 1'b1, -1);
    waitTicks(170);
    check(asleep == 1, "R11", "no wake on final bit 0 or idle", 32'(asleep), 1);
    check(idleFlag == 0, "R9", "idle flag muted while asleep", 32'(idleFlag), 0);
    expectFrame(9'h091, 1'b0, "R11"); sendFrame(9'h091, 1'b1, -1);
    check(asleep == 0, "R11", "woken by mark", 32'(asleep), 0);
    wakeAddr = 1'b0;

    // R12: input selection
    loopTx = 1'b1; loopEn = 1'b1; drvSel = 1; rxPin = 1'b0;
    expectFrame(9'h06E, 1'b0, "R12"); sendFrame(9'h06E, 1'b1, -1);
    txPinIn = 1'b1; singleWire = 1'b1; drvSel = 2; loopTx = 1'b0;
    expectFrame(9'h029, 1'b0, "R12"); sendFrame(9'h029, 1'b1, -1);
    rxPin = 1'b1; loopEn = 1'b0; singleWire = 1'b0; drvSel = 0; loopTx = 1'b1;
    expectFrame(9'h0E7, 1'b0, "R12"); sendFrame(9'h0E7, 1'b1, -1);

    waitTicks(20);
    check(expQ.size() == 0, "R13", "all characters delivered", 32'(expQ.size()), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule